// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block is the fetch half of a split fetch/execute processor front end. It holds a six-byte first-in-first-out code buffer. Bytes enter at the tail from code-fetch bus cycles, and the execution side removes them from the head. Whenever the buffer has room and the bus is idle, the controller starts a fixed four-cycle code read on its own. Each read brings in a 16-bit word from an even address, or a single byte when the fetch address is odd, so that later reads are word-aligned.

The execution side has priority on the bus. While it holds its data request, no new code read is started. A code read that is already running is allowed to finish. The consumer asks for between one and six bytes at a time. A request is honoured only when that many bytes are present; otherwise the consumer is told to wait. When a taken branch is reported, the buffer is emptied and the fetch pointer is reloaded with the target. The word from any code read still in progress is thrown away when it returns. A branch reported as not taken leaves everything as it was.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted, occupancy is 0, codeReq is 0 and fetchPtr equals the RESET_ADDR parameter (default 0).
- R2: The buffer is strictly first-in-first-out. Byte slot i of headBytes (bits 8i+7..8i) holds the i-th oldest byte, bytes appear in ascending address order, and occupancy never exceeds 6.
- R3: A code read keeps codeReq high and codeAddr constant for exactly 4 cycles. Its bytes are counted in occupancy from the fourth rising edge after the edge that started it.
- R4: A read from an even address writes 2 bytes: first codeWord[7:0], then codeWord[15:8]. fetchPtr advances by 2 on the edge that starts the read.
- R5: A read from an odd address writes only codeWord[15:8]. fetchPtr advances by 1 on the start edge.
- R6: A read starts only when at least 2 bytes are free (even fetchPtr) or at least 1 byte is free (odd fetchPtr). Otherwise the fetch side stays idle with codeReq low.
- R7: While dataReq is high, no code read starts. dataGrant is high exactly when dataReq is high and no code read is in progress. A code read in progress is not cut short.
- R8: takeReady is high exactly when 1 <= takeCount <= occupancy. A take with takeValid and takeReady removes takeCount bytes from the head on that edge. Any other take changes nothing.
- R9: branchValid with branchTaken empties the buffer on that edge and loads fetchPtr with branchTarget. It overrides a take in the same cycle, and the bytes of a code read in progress at that time are never written.
- R10: branchValid with branchTaken low leaves occupancy, buffered bytes and fetchPtr unchanged.
- R11: A take and the completion of a code read on the same edge combine. Occupancy becomes old minus taken plus written, and the new bytes follow the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dataReq | input | 1 | Execution side wants the bus for a data access |
| dataGrant | output | 1 | Bus is handed to the data access |
| codeReq | output | 1 | Code read in progress |
| codeAddr | output | 20 | Address of the code read in progress |
| codeWord | input | 16 | Word returned by memory for codeAddr's aligned word |
| takeValid | input | 1 | Consumer requests bytes from the head |
| takeCount | input | 3 | Number of bytes requested, 1 to 6 |
| takeReady | output | 1 | Enough bytes present for the request |
| headBytes | output | 48 | Buffer contents, head in the low byte |
| branchValid | input | 1 | A branch outcome is reported this cycle |
| branchTaken | input | 1 | The reported branch is taken |
| branchTarget | input | 20 | Fetch address after a taken branch |
| occupancy | output | 3 | Bytes currently buffered, 0 to 6 |
| fetchPtr | output | 20 | Address of the next code read |

## Verification
Assertions check on every cycle that occupancy stays within the buffer depth, that the address holds steady during a code read, and that a taken branch always leaves the buffer empty. They also check that occupancy grows only through a completed write, that a new read never starts while a data request is pending, and that a read starts only with enough free room. Only the directed scenarios can show that the right bytes land in the right order, and that the odd-address single-byte read realigns the pointer. The same holds for dropping a word whose read was overtaken by a branch, for the ignored not-taken branch, and for the cycle-exact arrival time of fetched bytes.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef struct packed {
    logic flush;   // empty queue and reload pointer
    logic take;    // remove takeCount bytes from the head
    logic start;   // begin a code read at fetchPtr
    logic wrEn;    // write the returning code bytes
  } pfqStrobes_t;
endpackage

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pfqStrobes_t          st,
  input  logic [CNT_W-1:0]     takeCount,
  input  logic [15:0]          codeWord,
  input  logic [ADDR_W-1:0]    branchTarget,
  output logic [CNT_W-1:0]     occupancy,
  output logic [ADDR_W-1:0]    fetchPtr,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [DEPTH*8-1:0]   headBytes
);
  logic [7:0]       q     [DEPTH];
  logic [7:0]       qNext [DEPTH];
  logic [CNT_W-1:0] shiftN;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] wrN;
  logic [7:0]       lowByte;

  assign shiftN  = st.take ? takeCount : '0;
  assign base    = occupancy - shiftN;
  assign wrN     = st.wrEn ? (busAddr[0] ? CNT_W'(1) : CNT_W'(2)) : '0;
  assign lowByte = busAddr[0] ? codeWord[15:8] : codeWord[7:0];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : gSlot
    always_comb begin
      qNext[gi] = 8'h00;
      for (int k = 0; k < DEPTH; k++) begin
        if ((CNT_W+1)'(k) == (CNT_W+1)'(gi) + {1'b0, shiftN}) qNext[gi] = q[k];
      end
      if (st.wrEn && CNT_W'(gi) == base) qNext[gi] = lowByte;
      if (st.wrEn && !busAddr[0] && CNT_W'(gi) == base + 1'b1) qNext[gi] = codeWord[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[gi] <= 8'h00;
      else        q[gi] <= qNext[gi];
    end

    assign headBytes[gi*8 +: 8] = q[gi];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occupancy <= '0;
      fetchPtr  <= RESET_ADDR;
      busAddr   <= RESET_ADDR;
    end else begin
      occupancy <= st.flush ? '0 : occupancy - shiftN + wrN;
      if (st.flush) fetchPtr <= branchTarget;
      else if (st.start) fetchPtr <= fetchPtr + (fetchPtr[0] ? ADDR_W'(1) : ADDR_W'(2));
      if (st.start) busAddr <= fetchPtr;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st.flush) |-> occupancy == '0);

  // R3
  growth_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy > $past(occupancy)) |-> $past(st.wrEn));
endmodule

// File: rtl/pfq_control.sv
module pfq_control
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int FETCH_CYCLES = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occupancy,
  input  logic             ptrOdd,
  input  logic             dataReq,
  input  logic             takeValid,
  input  logic [CNT_W-1:0] takeCount,
  input  logic             branchValid,
  input  logic             branchTaken,
  output pfqStrobes_t      st,
  output logic             codeReq,
  output logic             dataGrant,
  output logic             takeReady
);
  localparam int CYC_W = (FETCH_CYCLES > 1) ? $clog2(FETCH_CYCLES) : 1;

  logic             busy;
  logic             drop;
  logic [CYC_W-1:0] cnt;
  logic             flushNow;
  logic             lastCycle;
  logic             startNow;
  logic [CNT_W-1:0] freeBytes;
  logic [CNT_W-1:0] needBytes;

  assign flushNow  = branchValid && branchTaken;
  assign lastCycle = busy && (cnt == CYC_W'(FETCH_CYCLES - 1));
  assign freeBytes = CNT_W'(DEPTH) - occupancy;
  assign needBytes = ptrOdd ? CNT_W'(1) : CNT_W'(2);
  assign startNow  = !busy && !dataReq && !flushNow && (freeBytes >= needBytes);
  assign takeReady = (takeCount != '0) && (takeCount <= occupancy);

  always_comb begin
    st       = '0;
    st.flush = flushNow;
    st.take  = takeValid && takeReady && !flushNow;
    st.start = startNow;
    st.wrEn  = lastCycle && !drop && !flushNow;
  end

  assign codeReq   = busy;
  assign dataGrant = dataReq && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      drop <= 1'b0;
    end else begin
      if (startNow) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (lastCycle) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (lastCycle)             drop <= 1'b0;
      else if (flushNow && busy) drop <= 1'b1;
    end
  end

  // R7
  data_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dataReq && !busy) |=> !busy);

  // R6
  room_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ({1'b0, $past(occupancy)} + ($past(ptrOdd) ? 1 : 2) <= DEPTH));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int ADDR_W = 20,
  parameter int FETCH_CYCLES = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dataReq,
  output logic               dataGrant,
  output logic               codeReq,
  output logic [ADDR_W-1:0]  codeAddr,
  input  logic [15:0]        codeWord,
  input  logic               takeValid,
  input  logic [CNT_W-1:0]   takeCount,
  output logic               takeReady,
  output logic [DEPTH*8-1:0] headBytes,
  input  logic               branchValid,
  input  logic               branchTaken,
  input  logic [ADDR_W-1:0]  branchTarget,
  output logic [CNT_W-1:0]   occupancy,
  output logic [ADDR_W-1:0]  fetchPtr
);
  pfqStrobes_t st;

  pfq_control #(.DEPTH(DEPTH), .FETCH_CYCLES(FETCH_CYCLES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .ptrOdd(fetchPtr[0]),
    .dataReq(dataReq), .takeValid(takeValid), .takeCount(takeCount),
    .branchValid(branchValid), .branchTaken(branchTaken), .st(st),
    .codeReq(codeReq), .dataGrant(dataGrant), .takeReady(takeReady)
  );

  pfq_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .CNT_W(CNT_W)) uData (
    .clk(clk), .rst_n(rst_n), .st(st), .takeCount(takeCount), .codeWord(codeWord),
    .branchTarget(branchTarget), .occupancy(occupancy), .fetchPtr(fetchPtr),
    .busAddr(codeAddr), .headBytes(headBytes)
  );

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (codeReq && $past(codeReq)) |-> $stable(codeAddr));
endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dataReq = 1'b1;
  logic        dataGrant, codeReq, takeReady;
  logic [19:0] codeAddr, fetchPtr;
  logic [15:0] codeWord;
  logic        takeValid = 1'b0;
  logic [2:0]  takeCount = 3'd0;
  logic [47:0] headBytes;
  logic        branchValid = 1'b0, branchTaken = 1'b0;
  logic [19:0] branchTarget = '0;
  logic [2:0]  occupancy;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0};
  endfunction

  always_comb codeWord = {mb({codeAddr[19:1], 1'b1}), mb({codeAddr[19:1], 1'b0})};

  prefetch_queue uut (
    .clk(clk), .rst_n(rst_n), .dataReq(dataReq), .dataGrant(dataGrant),
    .codeReq(codeReq), .codeAddr(codeAddr), .codeWord(codeWord),
    .takeValid(takeValid), .takeCount(takeCount), .takeReady(takeReady),
    .headBytes(headBytes), .branchValid(branchValid), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .occupancy(occupancy), .fetchPtr(fetchPtr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkBytes(input string req, input logic [19:0] a0, input int n);
    for (int i = 0; i < n; i++) check(req, 32'(headBytes[i*8 +: 8]), 32'(mb(a0 + 20'(i))));
  endtask

  task automatic redirect(input logic [19:0] tgt);
    branchValid = 1'b1; branchTaken = 1'b1; branchTarget = tgt;
    tick(1);
    branchValid = 1'b0; branchTaken = 1'b0;
  endtask

  task automatic takeOnce(input int n);
    takeValid = 1'b1; takeCount = 3'(n);
    tick(1);
    takeValid = 1'b0; takeCount = 3'd0;
  endtask

  task automatic testReset();
    #1;
    check("R1 occupancy", 32'(occupancy), 0);
    check("R1 codeReq", 32'(codeReq), 0);
    check("R1 fetchPtr", 32'(fetchPtr), 0);
    tick(2);
    rst_n = 1'b1;
    tick(3);
    check("R7 no fetch under dataReq", 32'(codeReq), 0);
    check("R7 grant", 32'(dataGrant), 1);
  endtask

  task automatic testEvenFill();
    redirect(20'h00100);
    check("R9 pointer load", 32'(fetchPtr), 32'h100);
    dataReq = 1'b0;
    tick(1);
    check("R3 codeReq after start", 32'(codeReq), 1);
    check("R3 codeAddr", 32'(codeAddr), 32'h100);
    check("R4 pointer +2", 32'(fetchPtr), 32'h102);
    tick(3);
    check("R3 not yet written", 32'(occupancy), 0);
    check("R3 addr held", 32'(codeAddr), 32'h100);
    tick(1);
    check("R3 written on fourth edge", 32'(occupancy), 2);
    checkBytes("R4 byte order", 20'h00100, 2);
    tick(10);
    check("R2 full", 32'(occupancy), 6);
    check("R6 idle when full", 32'(codeReq), 0);
    check("R4 pointer", 32'(fetchPtr), 32'h106);
    checkBytes("R2 fifo order", 20'h00100, 6);
  endtask

  task automatic testTake();
    takeCount = 3'd3;
    #1;
    check("R8 ready for 3", 32'(takeReady), 1);
    takeOnce(3);
    check("R8 after take 3", 32'(occupancy), 3);
    checkBytes("R8 head moved", 20'h00103, 3);
    takeCount = 3'd4; #1;
    check("R8 not ready for 4", 32'(takeReady), 0);
    takeCount = 3'd0; #1;
    check("R8 zero never ready", 32'(takeReady), 0);
    takeCount = 3'd7; #1;
    check("R8 seven never ready", 32'(takeReady), 0);
    takeOnce(4);
    check("R8 refused take ignored", 32'(occupancy), 3);
    checkBytes("R8 refused take head", 20'h00103, 3);
  endtask

  task automatic testOdd();
    dataReq = 1'b1;
    tick(6);
    redirect(20'h00201);
    check("R9 occupancy", 32'(occupancy), 0);
    dataReq = 1'b0;
    tick(1);
    check("R5 pointer +1", 32'(fetchPtr), 32'h202);
    tick(4);
    check("R5 one byte", 32'(occupancy), 1);
    checkBytes("R5 high byte", 20'h00201, 1);
    tick(20);
    check("R6 stop with one free", 32'(occupancy), 5);
    check("R6 codeReq idle", 32'(codeReq), 0);
    check("R6 pointer", 32'(fetchPtr), 32'h206);
    checkBytes("R2 realigned order", 20'h00201, 5);
  endtask

  task automatic testFlushInFlight();
    takeOnce(5);
    check("R8 take 5", 32'(occupancy), 0);
    tick(2);
    check("R9 read in flight", 32'(codeReq), 1);
    dataReq = 1'b1;
    redirect(20'h00300);
    check("R9 emptied", 32'(occupancy), 0);
    check("R9 pointer", 32'(fetchPtr), 32'h300);
    tick(2);
    check("R9 dropped data", 32'(occupancy), 0);
    check("R7 grant after read", 32'(dataGrant), 1);
  endtask

  task automatic testNotTaken();
    dataReq = 1'b0;
    tick(15);
    check("R10 full before", 32'(occupancy), 6);
    branchValid = 1'b1; branchTaken = 1'b0; branchTarget = 20'h00555;
    tick(1);
    branchValid = 1'b0;
    check("R10 occupancy kept", 32'(occupancy), 6);
    check("R10 pointer kept", 32'(fetchPtr), 32'h306);
    checkBytes("R10 bytes kept", 20'h00300, 6);
  endtask

  task automatic testConcurrent();
    takeOnce(2);
    check("R11 after take 2", 32'(occupancy), 4);
    tick(4);
    check("R11 read busy", 32'(codeReq), 1);
    takeOnce(1);
    check("R11 combined count", 32'(occupancy), 5);
    checkBytes("R11 combined order", 20'h00303, 5);
    tick(3);
    check("R11 idle after", 32'(codeReq), 0);
  endtask

  task automatic testPriority();
    dataReq = 1'b1;
    branchValid = 1'b1; branchTaken = 1'b1; branchTarget = 20'h00400;
    takeValid = 1'b1; takeCount = 3'd1;
    tick(1);
    branchValid = 1'b0; branchTaken = 1'b0; takeValid = 1'b0;
    check("R9 flush beats take", 32'(occupancy), 0);
    tick(8);
    check("R7 held off", 32'(codeReq), 0);
    check("R7 grant held", 32'(dataGrant), 1);
    dataReq = 1'b0;
    tick(1);
    check("R7 read started", 32'(codeReq), 1);
    dataReq = 1'b1; #1;
    check("R7 no grant while busy", 32'(dataGrant), 0);
    tick(4);
    check("R7 read completed", 32'(occupancy), 2);
    check("R7 grant after read", 32'(dataGrant), 1);
    checkBytes("R7 bytes", 20'h00400, 2);
  endtask

  initial begin
    testReset();
    testEvenFill();
    testTake();
    testOdd();
    testFlushInFlight();
    testNotTaken();
    testConcurrent();
    testPriority();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule